// File: doc/BRIEF.md
# Memory-to-Register Gather Acceptance Checker

This block decides whether a decoded memory-to-register gather instruction may be issued. The gather reads a two-dimensional strided set of scalar elements from a single base address and writes each element into a named register. Before execution, the instruction word must satisfy a fixed set of acceptance rules: the right opcode, register destinations only, bounded element counts, a whitelisted element type, even register numbers when elements are 64 bits wide, a base address aligned to the element size, and a span of touched addresses that stays inside one aligned 16 MB region.

The decode front end presents the pre-split fields together with a one-cycle strobe. Header and event well-formedness arrive as one flag that an earlier stage computes. One cycle after the strobe, the checker returns an accept flag and an error code. The error code names the highest-priority rule that failed. The load itself is performed elsewhere.

Top module: `mrl_accept_check`

## Requirements
- R1: When `hdr_ok` is low on a strobe, the result is a reject with error code 1 (header), whatever the other fields hold.
- R2: An opcode other than 0xAA is rejected with error code 2.
- R3: A data-source value other than 0 (register destinations) is rejected with error code 3; the value 1 (immediate) is among those rejected.
- R4: Each element count must lie in 1..32, and the product of the two counts must be at most 32; otherwise the error code is 4.
- R5: Only type codes 0x1 (u64), 0x2 (i8), 0x3 (u8), 0x4 (i16), 0x5 (u16), 0x8 (i32), 0x9 (u32) and 0xA (fp32) are accepted; every other code gives error code 4'd5.
- R6: With type 0x1, all 32 register slots must hold even numbers, including unused slots. Slot k occupies bits [8k+7:8k] of `dst_regs`. A slot with bit 0 set gives error code 6. For other types, odd register numbers are allowed.
- R7: The base address must be a multiple of the element size: 1 byte for 8-bit types, 2 for 16-bit, 4 for 32-bit and fp32, 8 for u64. Otherwise the error code is 7.
- R8: Each element's address is base + (i0·stride0 + i1·stride1)·size, with signed strides. If the lowest and highest such addresses differ in bits [63:24], the error code is 8.
- R9: When several rules fail, the lowest-numbered error code is reported. The order is header, opcode, source, counts, type, even registers, alignment, window.
- R10: `out_valid` is high exactly one cycle after `in_valid`. `accept` is high exactly when the error code is 0. Without a strobe, `accept` and `err_code` keep their last values.
- R11: During and right after reset, `out_valid`, `accept` and `err_code` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Strobe: fields below are valid this cycle |
| hdr_ok | input | 1 | Header and event fields well formed |
| opcode | input | 8 | Header opcode byte |
| src_sel | input | 8 | Data-source field (0 = registers) |
| type_code | input | 8 | Element type code |
| cnt0 | input | 8 | Inner element count |
| cnt1 | input | 8 | Outer element count |
| base_addr | input | 64 | Resolved base byte address |
| stride0 | input | 32 | Signed inner stride in elements |
| stride1 | input | 32 | Signed outer stride in elements |
| dst_regs | input | 256 | 32 destination register numbers, slot k at [8k+7:8k] |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| accept | output | 1 | Instruction may be issued |
| err_code | output | 4 | First failing rule, 0 when accepted |

## Verification
The verdict and error code for a strobe are due at the clock edge that follows it. That is one register stage, and it applies to every rule. The bench drives each case on a falling edge, lets exactly one rising edge pass, and samples on the next falling edge. It then waits one more idle cycle before the next case, so that the `out_valid` drop and the held outputs can also be observed. Expected codes come from a brute-force model in the bench, which walks every element address to find the span.

// File: rtl/mrl_pkg.sv
package mrl_pkg;

    typedef enum logic [3:0] {
        ERR_NONE    = 4'd0,
        ERR_HEADER  = 4'd1,
        ERR_OPCODE  = 4'd2,
        ERR_SOURCE  = 4'd3,
        ERR_COUNT   = 4'd4,
        ERR_TYPE    = 4'd5,
        ERR_ODD_REG = 4'd6,
        ERR_ALIGN   = 4'd7,
        ERR_WINDOW  = 4'd8
    } mrl_err_e;

    localparam logic [7:0] LOAD_OPCODE = 8'hAA;
    localparam logic [7:0] SRC_REGS    = 8'h00;

    localparam logic [7:0] TY_U64  = 8'h01;
    localparam logic [7:0] TY_I8   = 8'h02;
    localparam logic [7:0] TY_U8   = 8'h03;
    localparam logic [7:0] TY_I16  = 8'h04;
    localparam logic [7:0] TY_U16  = 8'h05;
    localparam logic [7:0] TY_I32  = 8'h08;
    localparam logic [7:0] TY_U32  = 8'h09;
    localparam logic [7:0] TY_FP32 = 8'h0A;

    typedef struct packed {
        logic     vld;
        logic     accept;
        mrl_err_e err;
    } mrl_state_t;

endpackage

// File: rtl/mrl_field_rules.sv
module mrl_field_rules #(
    parameter int CNT_W     = 8,
    parameter int MAX_ELEMS = 32
) (
    input  logic [7:0]       opcode,
    input  logic [7:0]       src_sel,
    input  logic [7:0]       type_code,
    input  logic [CNT_W-1:0] cnt0,
    input  logic [CNT_W-1:0] cnt1,
    output logic             opcode_ok,
    output logic             src_ok,
    output logic             count_ok,
    output logic             type_ok,
    output logic             is_u64,
    output logic [1:0]       size_log2
);
    import mrl_pkg::*;

    localparam int PROD_W = 2 * CNT_W;
    localparam logic [CNT_W-1:0]  CNT_MAX  = CNT_W'(MAX_ELEMS);
    localparam logic [PROD_W-1:0] PROD_MAX = PROD_W'(MAX_ELEMS);

    logic [PROD_W-1:0] prod;
    logic              cnt0_in, cnt1_in;

    always_comb begin
        opcode_ok = (opcode == LOAD_OPCODE);
        src_ok    = (src_sel == SRC_REGS);
        cnt0_in   = (cnt0 != '0) && (cnt0 <= CNT_MAX);
        cnt1_in   = (cnt1 != '0) && (cnt1 <= CNT_MAX);
        prod      = PROD_W'(cnt0) * PROD_W'(cnt1);
        count_ok  = cnt0_in && cnt1_in && (prod <= PROD_MAX);
    end

    always_comb begin
        type_ok   = 1'b1;
        size_log2 = 2'd0;
        unique case (type_code)
            TY_U8, TY_I8:           size_log2 = 2'd0;
            TY_U16, TY_I16:         size_log2 = 2'd1;
            TY_U32, TY_I32, TY_FP32: size_log2 = 2'd2;
            TY_U64:                 size_log2 = 2'd3;
            default: begin
                type_ok   = 1'b0;
                size_log2 = 2'd0;
            end
        endcase
        is_u64 = (type_code == TY_U64);
    end

endmodule

// File: rtl/mrl_pair_rule.sv
module mrl_pair_rule #(
    parameter int SLOTS = 32,
    parameter int REG_W = 8
) (
    input  logic [SLOTS*REG_W-1:0] slots,
    output logic                   odd_any
);
    logic [SLOTS-1:0]           lsb_vec;
    logic [SLOTS*(REG_W-1)-1:0] upper_vec;
    logic                       upper_unused;

    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        assign lsb_vec[k] = slots[k*REG_W];
        assign upper_vec[k*(REG_W-1) +: (REG_W-1)] = slots[k*REG_W+1 +: (REG_W-1)];
    end

    assign odd_any      = |lsb_vec;
    assign upper_unused = ^upper_vec;

endmodule

// File: rtl/mrl_span_rule.sv
module mrl_span_rule #(
    parameter int ADDR_W   = 64,
    parameter int STRIDE_W = 32,
    parameter int CNT_W    = 8,
    parameter int WIN_LSB  = 24
) (
    input  logic [ADDR_W-1:0]   base_addr,
    input  logic [STRIDE_W-1:0] stride0,
    input  logic [STRIDE_W-1:0] stride1,
    input  logic [CNT_W-1:0]    cnt0,
    input  logic [CNT_W-1:0]    cnt1,
    input  logic [1:0]          size_log2,
    output logic                aligned,
    output logic                same_window
);
    localparam int PAD_C = ADDR_W - CNT_W;
    localparam int PAD_S = ADDR_W - STRIDE_W;

    logic signed [ADDR_W-1:0] last0, last1, s0x, s1x, run0, run1;
    logic signed [ADDR_W-1:0] lo_el, hi_el, lo_b, hi_b;
    logic        [ADDR_W-1:0] min_addr, max_addr;

    always_comb begin
        last0 = $signed({{PAD_C{1'b0}}, cnt0}) - $signed(ADDR_W'(1));
        last1 = $signed({{PAD_C{1'b0}}, cnt1}) - $signed(ADDR_W'(1));
        s0x   = $signed({{PAD_S{stride0[STRIDE_W-1]}}, stride0});
        s1x   = $signed({{PAD_S{stride1[STRIDE_W-1]}}, stride1});
        run0  = last0 * s0x;
        run1  = last1 * s1x;
        lo_el = (run0[ADDR_W-1] ? run0 : '0) + (run1[ADDR_W-1] ? run1 : '0);
        hi_el = (run0[ADDR_W-1] ? '0 : run0) + (run1[ADDR_W-1] ? '0 : run1);
        lo_b  = lo_el <<< size_log2;
        hi_b  = hi_el <<< size_log2;
        min_addr    = base_addr + ADDR_W'(lo_b);
        max_addr    = base_addr + ADDR_W'(hi_b);
        same_window = (min_addr[ADDR_W-1:WIN_LSB] == max_addr[ADDR_W-1:WIN_LSB]);
    end

    always_comb begin
        unique case (size_log2)
            2'd0: aligned = 1'b1;
            2'd1: aligned = (base_addr[0] == 1'b0);
            2'd2: aligned = (base_addr[1:0] == 2'b00);
            default: aligned = (base_addr[2:0] == 3'b000);
        endcase
    end

endmodule

// File: rtl/mrl_accept_check.sv
module mrl_accept_check #(
    parameter int ADDR_W    = 64,
    parameter int STRIDE_W  = 32,
    parameter int CNT_W     = 8,
    parameter int SLOTS     = 32,
    parameter int REG_W     = 8,
    parameter int MAX_ELEMS = 32,
    parameter int WIN_LSB   = 24
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic                   hdr_ok,
    input  logic [7:0]             opcode,
    input  logic [7:0]             src_sel,
    input  logic [7:0]             type_code,
    input  logic [CNT_W-1:0]       cnt0,
    input  logic [CNT_W-1:0]       cnt1,
    input  logic [ADDR_W-1:0]      base_addr,
    input  logic [STRIDE_W-1:0]    stride0,
    input  logic [STRIDE_W-1:0]    stride1,
    input  logic [SLOTS*REG_W-1:0] dst_regs,
    output logic                   out_valid,
    output logic                   accept,
    output logic [3:0]             err_code
);
    import mrl_pkg::*;

    logic       opcode_ok, src_ok, count_ok, type_ok, is_u64;
    logic [1:0] size_log2;
    logic       odd_any, aligned, same_window;

    mrl_state_t st_d, st_q;

    mrl_field_rules #(.CNT_W(CNT_W), .MAX_ELEMS(MAX_ELEMS)) u_fields (
        .opcode    (opcode),
        .src_sel   (src_sel),
        .type_code (type_code),
        .cnt0      (cnt0),
        .cnt1      (cnt1),
        .opcode_ok (opcode_ok),
        .src_ok    (src_ok),
        .count_ok  (count_ok),
        .type_ok   (type_ok),
        .is_u64    (is_u64),
        .size_log2 (size_log2)
    );

    mrl_pair_rule #(.SLOTS(SLOTS), .REG_W(REG_W)) u_pairs (
        .slots   (dst_regs),
        .odd_any (odd_any)
    );

    mrl_span_rule #(
        .ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W), .CNT_W(CNT_W), .WIN_LSB(WIN_LSB)
    ) u_span (
        .base_addr   (base_addr),
        .stride0     (stride0),
        .stride1     (stride1),
        .cnt0        (cnt0),
        .cnt1        (cnt1),
        .size_log2   (size_log2),
        .aligned     (aligned),
        .same_window (same_window)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            if (!hdr_ok)                 st_d.err = ERR_HEADER;
            else if (!opcode_ok)         st_d.err = ERR_OPCODE;
            else if (!src_ok)            st_d.err = ERR_SOURCE;
            else if (!count_ok)          st_d.err = ERR_COUNT;
            else if (!type_ok)           st_d.err = ERR_TYPE;
            else if (is_u64 && odd_any)  st_d.err = ERR_ODD_REG;
            else if (!aligned)           st_d.err = ERR_ALIGN;
            else if (!same_window)       st_d.err = ERR_WINDOW;
            else                         st_d.err = ERR_NONE;
            st_d.accept = (st_d.err == ERR_NONE);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{vld: 1'b0, accept: 1'b0, err: ERR_NONE};
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign accept    = st_q.accept;
    assign err_code  = st_q.err;

    a_r10_strobe_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r10_no_strobe_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    a_r2_opcode_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && hdr_ok && opcode != 8'hAA) |=> (!accept && err_code == 4'd2));

    a_r4_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (cnt0 == '0 || cnt1 == '0)) |=> !accept);

    a_r6_u64_odd_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && type_code == 8'h01 && dst_regs[0]) |=> !accept);

    a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(accept) && $stable(err_code)));

endmodule

// File: tb/mrl_accept_check_tb_top.sv
module mrl_accept_check_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         hdr_ok = 1'b1;
    logic [7:0]   opcode = 8'hAA;
    logic [7:0]   src_sel = 8'h00;
    logic [7:0]   type_code = 8'h03;
    logic [7:0]   cnt0 = 8'd1;
    logic [7:0]   cnt1 = 8'd1;
    logic [63:0]  base_addr = '0;
    logic [31:0]  stride0 = 32'd1;
    logic [31:0]  stride1 = 32'd1;
    logic [255:0] dst_regs = '0;
    logic         out_valid, accept;
    logic [3:0]   err_code;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mrl_accept_check dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .hdr_ok(hdr_ok),
        .opcode(opcode), .src_sel(src_sel), .type_code(type_code),
        .cnt0(cnt0), .cnt1(cnt1), .base_addr(base_addr),
        .stride0(stride0), .stride1(stride1), .dst_regs(dst_regs),
        .out_valid(out_valid), .accept(accept), .err_code(err_code)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG) begin
            n_tests = n_tests + 1;
            n_fail  = n_fail + 1;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected<=%0d", cycles, WATCHDOG);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    function automatic int elem_size(logic [7:0] ty);
        case (ty)
            8'h02, 8'h03: return 1;
            8'h04, 8'h05: return 2;
            8'h08, 8'h09, 8'h0A: return 4;
            8'h01: return 8;
            default: return 0;
        endcase
    endfunction

    function automatic int ref_code();
        int sz;
        longint off, lo, hi;
        logic [63:0] amin, amax;
        if (!hdr_ok) return 1;
        if (opcode != 8'hAA) return 2;
        if (src_sel != 8'h00) return 3;
        if (cnt0 < 1 || cnt0 > 32 || cnt1 < 1 || cnt1 > 32 || int'(cnt0) * int'(cnt1) > 32) return 4;
        sz = elem_size(type_code);
        if (sz == 0) return 5;
        if (type_code == 8'h01)
            for (int k = 0; k < 32; k++) if (dst_regs[8*k]) return 6;
        if ((base_addr % 64'(sz)) != 0) return 7;
        lo = 0; hi = 0;
        for (int i1 = 0; i1 < int'(cnt1); i1++)
            for (int i0 = 0; i0 < int'(cnt0); i0++) begin
                off = (longint'(i0) * longint'($signed(stride0)) +
                       longint'(i1) * longint'($signed(stride1))) * longint'(sz);
                if (off < lo) lo = off;
                if (off > hi) hi = off;
            end
        amin = base_addr + 64'(lo);
        amax = base_addr + 64'(hi);
        if (amin[63:24] != amax[63:24]) return 8;
        return 0;
    endfunction

    task automatic check(string req, bit cond, int act, int exp);
        n_tests++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // drive on a falling edge, one rising edge registers, sample at next falling edge
    task automatic run_case(string req);
        int exp;
        @(negedge clk);
        exp = ref_code();
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(req, out_valid === 1'b1 && err_code === 4'(exp) && accept === (exp == 0),
              int'(err_code) + (out_valid ? 0 : 100), exp);
    endtask

    task automatic set_ok();
        hdr_ok = 1'b1; opcode = 8'hAA; src_sel = 8'h00; type_code = 8'h09;
        cnt0 = 8'd4; cnt1 = 8'd2; base_addr = 64'h0000_1000_0010_0000;
        stride0 = 32'd1; stride1 = 32'd4; dst_regs = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R11 reset", out_valid === 1'b0 && accept === 1'b0 && err_code === 4'd0,
              int'(err_code) + (out_valid ? 100 : 0), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 after reset", out_valid === 1'b0 && accept === 1'b0 && err_code === 4'd0,
              int'(err_code), 0);

        set_ok(); run_case("R10 clean accept");
        check("R10 drop", 1'b1, 0, 0);
        @(negedge clk);
        check("R10 out_valid low and held", out_valid === 1'b0 && accept === 1'b1 && err_code === 4'd0,
              int'(err_code) + (out_valid ? 100 : 0), 0);

        // R1 header dominates all
        set_ok(); hdr_ok = 1'b0; opcode = 8'h00; src_sel = 8'h01; run_case("R1 header");
        set_ok(); hdr_ok = 1'b0; run_case("R1 header alone");
        @(negedge clk);
        check("R10 reject held idle", out_valid === 1'b0 && accept === 1'b0 && err_code === 4'd1,
              int'(err_code), 1);

        // R2 opcode sweep
        for (int op = 0; op < 256; op++) begin
            set_ok(); opcode = 8'(op); run_case("R2 opcode");
        end
        // R3 source sweep
        for (int s = 0; s < 256; s++) begin
            set_ok(); src_sel = 8'(s); run_case("R3 source");
        end
        // R4 count sweep
        for (int a = 0; a < 34; a++)
            for (int b = 0; b < 34; b++) begin
                set_ok(); type_code = 8'h03; base_addr = 64'h40; stride0 = 32'd1; stride1 = 32'd8;
                cnt0 = 8'(a); cnt1 = 8'(b); run_case("R4 counts");
            end
        set_ok(); cnt0 = 8'd255; cnt1 = 8'd1; run_case("R4 count 255");
        // R5 type sweep with alignment variants (R7)
        for (int t = 0; t < 256; t++)
            for (int lo = 0; lo < 8; lo++) begin
                set_ok(); type_code = 8'(t); base_addr = 64'h2000 + 64'(lo); run_case("R5 R7 type align");
            end
        // R6 odd slot per position
        for (int k = 0; k < 32; k++) begin
            set_ok(); type_code = 8'h01; base_addr = 64'h800; cnt0 = 8'd1; cnt1 = 8'd1;
            dst_regs[8*k] = 1'b1; run_case("R6 u64 odd slot");
            type_code = 8'h09; run_case("R6 u32 odd slot allowed");
        end
        set_ok(); type_code = 8'h01; base_addr = 64'h800;
        for (int k = 0; k < 32; k++) dst_regs[8*k +: 8] = 8'(2*k);
        run_case("R6 u64 even regs");
        // R8 window boundary cases
        set_ok(); type_code = 8'h03; cnt0 = 8'd2; cnt1 = 8'd1; stride0 = 32'd1;
        base_addr = 64'h00FF_FFFF; run_case("R8 cross up");
        base_addr = 64'h00FF_FFFE; run_case("R8 fit at top");
        set_ok(); type_code = 8'h09; cnt0 = 8'd2; cnt1 = 8'd1; stride0 = 32'hFFFF_FFFF;
        base_addr = 64'h0100_0000; run_case("R8 negative stride cross");
        base_addr = 64'h0100_0004; run_case("R8 negative stride fit");
        set_ok(); type_code = 8'h01; cnt0 = 8'd4; cnt1 = 8'd8; stride0 = 32'h0008_0000; stride1 = 32'hFFFF_FFFF;
        base_addr = 64'h0300_0040; run_case("R8 mixed strides");
        // R9 priority pairs
        set_ok(); opcode = 8'h01; src_sel = 8'h01; run_case("R9 opcode over source");
        set_ok(); src_sel = 8'h01; cnt0 = 8'd0; run_case("R9 source over counts");
        set_ok(); cnt0 = 8'd40; type_code = 8'h06; run_case("R9 counts over type");
        set_ok(); type_code = 8'h01; dst_regs[8] = 1'b1; base_addr = 64'h3; run_case("R9 odd over align");
        set_ok(); base_addr = 64'h00FF_FFF1; stride0 = 32'd4096; run_case("R9 align over window");
        // mixed pseudo-random cases
        for (int n = 0; n < 3000; n++) begin
            hdr_ok = ($urandom_range(0, 15) != 0);
            opcode = ($urandom_range(0, 7) != 0) ? 8'hAA : 8'($urandom);
            src_sel = ($urandom_range(0, 7) != 0) ? 8'h00 : 8'($urandom_range(0, 3));
            type_code = 8'($urandom_range(0, 15));
            cnt0 = 8'($urandom_range(0, 33));
            cnt1 = 8'($urandom_range(0, 4));
            base_addr = {32'($urandom), 32'($urandom)} & (($urandom_range(0, 1) != 0) ? 64'hFFFF_FFFF_FFFF_FFF8 : '1);
            stride0 = ($urandom_range(0, 1) != 0) ? 32'($signed($urandom_range(0, 200)) - 100) : 32'($urandom);
            stride1 = 32'($signed($urandom_range(0, 400000)) - 200000);
            for (int k = 0; k < 32; k++) dst_regs[8*k +: 8] = 8'($urandom_range(0, 63)) & (($urandom_range(0, 63) != 0) ? 8'hFE : 8'hFF);
            run_case("R1 R2 R3 R4 R5 R6 R7 R8 R9 mixed");
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule